// File: doc/BRIEF.md
# Type B Reader Frame Bit Encoder

This block turns a frame of bytes into the serial bit sequence a proximity reader sends toward a card. The bytes arrive on a valid/ready stream with a last marker. One bit leaves on `tx_bit` for each cycle in which the bit-clock enable `bit_en` is high. Modulation, CRC generation and the bit-rate clock are supplied by the surrounding logic.

A frame has five parts in a fixed order. A run of ones sets a reference level. A run of zeros marks the start of frame. Each byte then goes out as a character: two high guard bits, a low start bit and eight data bits, least significant first. After the characters come an end-of-frame pattern and a block of trailing ones. The trailing ones let the last character drain completely before the link changes direction. `tx_busy` shows that the bit currently on the line belongs to a frame.

A byte can be taken only at a character boundary. This is the bit slot that opens a character, and it is decided by the `ST_GATE` state. If a byte is offered there and the last byte has not yet been taken, the slot becomes the first guard bit. Otherwise the same high slot becomes the end-of-frame marker. A stalled source therefore closes the frame cleanly.

The sequencer states and transitions are as follows. Each transition takes effect on a `bit_en` cycle, and each state emits the bit named for it.
- `ST_IDLE` goes to `ST_PRE` when `in_valid` is high.
- `ST_PRE` emits ones and goes to `ST_SOF` when its count runs out.
- `ST_SOF` emits zeros and then goes to `ST_GATE`.
- `ST_GATE` emits a one. It goes to `ST_GUARD` if it takes a byte, and to `ST_EOF_LOW` if it does not.
- `ST_GUARD` goes to `ST_START`.
- `ST_START` emits a zero and goes to `ST_DATA`.
- `ST_DATA` shifts out eight bits and returns to `ST_GATE`.
- `ST_EOF_LOW` emits zeros and goes to `ST_EOF_HIGH`.
- `ST_EOF_HIGH` emits ones and goes to `ST_PAD`.
- `ST_PAD` emits ones and goes back to `ST_IDLE`.

Top module: `typeb_tx_framer`

## Requirements
- R1: After reset and whenever no frame is on the line, `tx_bit` is 1 and `tx_busy` and `in_ready` are 0.
- R2: A frame starts on a `bit_en` cycle in idle with `in_valid` high. This start does not consume a byte. The frame opens with 40 one bits. `tx_busy` is 1 from the first of these bits through the last padding bit.
- R3: The 40 preamble bits are followed by exactly 10 zero bits (start of frame).
- R4: Each accepted byte is sent as 1, 1, 0, then its 8 data bits with bit 0 first.
- R5: `in_ready` is high only in a `bit_en` cycle at a character boundary. A byte transfers when `in_valid` and `in_ready` are both high, and each accepted byte is sent exactly once.
- R6: Once a byte with `in_last` high has been accepted, no further byte is accepted in that frame. The end-of-frame follows that byte's data bits.
- R7: The frame closes with one 1 bit, 10 zero bits and 8 one bits, followed by 24 padding one bits. A frame with N bytes is therefore 93 + 11·N bits long.
- R8: If no byte is valid at a character boundary before `in_last` has been seen, the frame ends at that boundary with the end-of-frame. This includes a frame with no bytes at all.
- R9: `tx_bit` and `tx_busy` change only on clock edges where `bit_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-clock enable; one line bit per high cycle |
| in_valid | input | 1 | Byte stream valid |
| in_data | input | 8 | Byte stream data |
| in_last | input | 1 | Marks the final byte of the frame |
| in_ready | output | 1 | Byte accepted in this cycle when in_valid is also high |
| tx_bit | output | 1 | Serial line bit, idles high |
| tx_busy | output | 1 | The bit on the line belongs to a frame |

## Verification
Two situations are hard to reach from the ports. The first is a boundary slot that must take no byte even though one is offered: the source keeps `in_valid` high with further bytes after the last-marked byte. The second is a source that stalls at a boundary. The bench builds both directly: it offers more bytes than the frame may take, and it withholds bytes after a chosen count, with zero bytes as the extreme case. In each case it compares the whole captured line sequence and the number of handshakes with the frame built from the requirements. Random frames with sparse `bit_en` patterns then check that outputs hold still between enables.

// File: rtl/typeb_enc_pkg.sv
package typeb_enc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_SOF,
        ST_GATE,
        ST_GUARD,
        ST_START,
        ST_DATA,
        ST_EOF_LOW,
        ST_EOF_HIGH,
        ST_PAD
    } enc_state_t;

endpackage

// File: rtl/typeb_enc_shreg.sv
module typeb_enc_shreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] din,
    output logic              lsb
);

    logic [DATA_W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= din;
        end else if (shift) begin
            sr_q <= {1'b0, sr_q[DATA_W-1:1]};
        end
    end

    assign lsb = sr_q[0];

endmodule

// File: rtl/typeb_enc_fsm.sv
module typeb_enc_fsm
    import typeb_enc_pkg::*;
#(
    parameter int PRE_LEN  = 40,
    parameter int SOF_LEN  = 10,
    parameter int EOFL_LEN = 10,
    parameter int EOFH_LEN = 8,
    parameter int PAD_LEN  = 24,
    parameter int DATA_W   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic in_valid,
    input  logic in_last,
    input  logic data_lsb,
    output logic in_ready,
    output logic load,
    output logic shift,
    output logic line_bit,
    output logic frame_bit
);

    localparam int MAX_A   = (PRE_LEN > SOF_LEN) ? PRE_LEN : SOF_LEN;
    localparam int MAX_B   = (EOFL_LEN > EOFH_LEN) ? EOFL_LEN : EOFH_LEN;
    localparam int MAX_C   = (PAD_LEN > DATA_W) ? PAD_LEN : DATA_W;
    localparam int MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_LEN = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    enc_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             last_q, last_d;
    logic             phase_end;

    assign phase_end = (cnt_q == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            last_q  <= 1'b0;
        end else if (bit_en) begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            last_q  <= last_d;
        end
    end

    // next state and per-bit outputs
    always_comb begin
        state_d   = state_q;
        cnt_d     = phase_end ? cnt_q : cnt_q - 1'b1;
        last_d    = last_q;
        line_bit  = 1'b1;
        frame_bit = 1'b1;
        in_ready  = 1'b0;
        load      = 1'b0;
        shift     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                frame_bit = in_valid;
                cnt_d     = '0;
                if (in_valid) begin
                    state_d = ST_PRE;
                    cnt_d   = CNT_W'(PRE_LEN - 2);
                    last_d  = 1'b0;
                end
            end
            ST_PRE: begin
                if (phase_end) begin
                    state_d = ST_SOF;
                    cnt_d   = CNT_W'(SOF_LEN - 1);
                end
            end
            ST_SOF: begin
                line_bit = 1'b0;
                if (phase_end) begin
                    state_d = ST_GATE;
                end
            end
            ST_GATE: begin
                in_ready = bit_en && !last_q;
                if (!last_q && in_valid) begin
                    load    = bit_en;
                    last_d  = in_last;
                    state_d = ST_GUARD;
                    cnt_d   = '0;
                end else begin
                    state_d = ST_EOF_LOW;
                    cnt_d   = CNT_W'(EOFL_LEN - 1);
                end
            end
            ST_GUARD: begin
                state_d = ST_START;
                cnt_d   = '0;
            end
            ST_START: begin
                line_bit = 1'b0;
                state_d  = ST_DATA;
                cnt_d    = CNT_W'(DATA_W - 1);
            end
            ST_DATA: begin
                line_bit = data_lsb;
                shift    = bit_en;
                if (phase_end) begin
                    state_d = ST_GATE;
                end
            end
            ST_EOF_LOW: begin
                line_bit = 1'b0;
                if (phase_end) begin
                    state_d = ST_EOF_HIGH;
                    cnt_d   = CNT_W'(EOFH_LEN - 1);
                end
            end
            ST_EOF_HIGH: begin
                if (phase_end) begin
                    state_d = ST_PAD;
                    cnt_d   = CNT_W'(PAD_LEN - 1);
                end
            end
            ST_PAD: begin
                if (phase_end) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d   = ST_IDLE;
                frame_bit = 1'b0;
                cnt_d     = '0;
            end
        endcase
    end

endmodule

// File: rtl/typeb_tx_framer.sv
module typeb_tx_framer #(
    parameter int PRE_LEN  = 40,
    parameter int SOF_LEN  = 10,
    parameter int EOFL_LEN = 10,
    parameter int EOFH_LEN = 8,
    parameter int PAD_LEN  = 24,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              tx_bit,
    output logic              tx_busy
);

    logic load, shift, data_lsb, line_bit, frame_bit;

    typeb_enc_fsm #(
        .PRE_LEN (PRE_LEN),
        .SOF_LEN (SOF_LEN),
        .EOFL_LEN(EOFL_LEN),
        .EOFH_LEN(EOFH_LEN),
        .PAD_LEN (PAD_LEN),
        .DATA_W  (DATA_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .in_valid (in_valid),
        .in_last  (in_last),
        .data_lsb (data_lsb),
        .in_ready (in_ready),
        .load     (load),
        .shift    (shift),
        .line_bit (line_bit),
        .frame_bit(frame_bit)
    );

    typeb_enc_shreg #(
        .DATA_W(DATA_W)
    ) u_shreg (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load),
        .shift(shift),
        .din  (in_data),
        .lsb  (data_lsb)
    );

    // output register: one update per bit slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_bit  <= 1'b1;
            tx_busy <= 1'b0;
        end else if (bit_en) begin
            tx_bit  <= line_bit;
            tx_busy <= frame_bit;
        end
    end

endmodule

// File: rtl/typeb_tx_framer_chk.sv
module typeb_tx_framer_chk #(
    parameter int EOFL_LEN = 10,
    parameter int EOFH_LEN = 8,
    parameter int PAD_LEN  = 24,
    parameter int DATA_W   = 8
) (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic in_valid,
    input logic in_last,
    input logic in_ready,
    input logic tx_bit,
    input logic tx_busy
);

    // bit slots left in the frame after a last-marked byte is taken
    localparam int TAIL = 3 + DATA_W + EOFL_LEN + EOFH_LEN + PAD_LEN;

    int tail_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tail_q <= 0;
        end else if (in_valid && in_ready && in_last) begin
            tail_q <= TAIL;
        end else if (bit_en && tail_q != 0) begin
            tail_q <= tail_q - 1;
        end
    end

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> tx_bit);

    assert_first_bit_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> tx_bit);

    assert_ready_in_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (bit_en && tx_busy));

    assert_no_take_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_q != 0) |-> !in_ready);

    assert_hold_between_enables_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(tx_bit) && $stable(tx_busy)));

endmodule

bind typeb_tx_framer typeb_tx_framer_chk #(
    .EOFL_LEN(EOFL_LEN),
    .EOFH_LEN(EOFH_LEN),
    .PAD_LEN (PAD_LEN),
    .DATA_W  (DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (bit_en),
    .in_valid(in_valid),
    .in_last (in_last),
    .in_ready(in_ready),
    .tx_bit  (tx_bit),
    .tx_busy (tx_busy)
);

// File: tb/sim_typeb_tx_framer.sv
module sim_typeb_tx_framer;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bit_en;
    logic       in_valid;
    logic [7:0] in_data;
    logic       in_last;
    logic       in_ready;
    logic       tx_bit;
    logic       tx_busy;

    always #5 clk = ~clk;

    typeb_tx_framer u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .in_valid(in_valid),
        .in_data (in_data),
        .in_last (in_last),
        .in_ready(in_ready),
        .tx_bit  (tx_bit),
        .tx_busy (tx_busy)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit wd      = 1'b0;

    bit         cap_q[$];
    bit         exp_q[$];
    logic [7:0] src_q[$];

    int idx, offer_lim, hs_cnt, last_idx, cutoff, en_mod, r9_bad;
    bit use_last, started, done, en_prev, rand_en, prev_tx;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // expected line sequence for the first n bytes of src_q
    function automatic void build(input int n);
        exp_q.delete();
        for (int i = 0; i < 40; i++) exp_q.push_back(1'b1);
        for (int i = 0; i < 10; i++) exp_q.push_back(1'b0);
        for (int b = 0; b < n; b++) begin
            exp_q.push_back(1'b1);
            exp_q.push_back(1'b1);
            exp_q.push_back(1'b0);
            for (int k = 0; k < 8; k++) exp_q.push_back(src_q[b][k]);
        end
        exp_q.push_back(1'b1);
        for (int i = 0; i < 10; i++) exp_q.push_back(1'b0);
        for (int i = 0; i < 32; i++) exp_q.push_back(1'b1);
    endfunction

    task automatic step();
        @(negedge clk);
        cycles++;
        if (cycles > 150000) wd = 1'b1;
        if (en_prev) begin
            prev_tx = tx_bit;
            if (tx_busy) begin
                cap_q.push_back(tx_bit);
                started = 1'b1;
            end else if (started) begin
                done = 1'b1;
            end
        end else if (started && !done && tx_bit !== prev_tx) begin
            r9_bad++;
        end
        bit_en   = rand_en ? (($urandom % en_mod) == 0) : 1'b1;
        in_valid = !started ? 1'b1
                 : ((idx < offer_lim) && (cap_q.size() < cutoff) && !done);
        in_data  = (idx < src_q.size()) ? src_q[idx] : 8'h00;
        in_last  = use_last && (idx == last_idx);
        #1;
        if (in_valid && in_ready) begin
            idx++;
            hs_cnt++;
        end
        en_prev = bit_en;
    endtask

    task automatic run_frame(input int n_exp, input int offer, input bit ul,
                             input int lidx, input string hs_req, input string name);
        int bad_pre, bad_sof, bad_chr, bad_eof, lim;
        cap_q.delete();
        idx = 0; hs_cnt = 0; r9_bad = 0;
        offer_lim = offer; use_last = ul; last_idx = lidx;
        started = 1'b0; done = 1'b0;
        build(n_exp);
        cutoff = exp_q.size() - 5;
        while (!done && !wd) step();
        in_valid = 1'b0;
        chk(cap_q.size() == exp_q.size(), "R7", {name, " frame length"},
            cap_q.size(), exp_q.size());
        bad_pre = 0; bad_sof = 0; bad_chr = 0; bad_eof = 0;
        lim = (cap_q.size() < exp_q.size()) ? cap_q.size() : exp_q.size();
        for (int i = 0; i < lim; i++) begin
            if (cap_q[i] != exp_q[i]) begin
                if (i < 40) bad_pre++;
                else if (i < 50) bad_sof++;
                else if (i < 50 + 11 * n_exp) bad_chr++;
                else bad_eof++;
            end
        end
        chk(bad_pre == 0, "R2", {name, " preamble bit errors"}, bad_pre, 0);
        chk(bad_sof == 0, "R3", {name, " start-of-frame bit errors"}, bad_sof, 0);
        chk(bad_chr == 0, "R4", {name, " character bit errors"}, bad_chr, 0);
        chk(bad_eof == 0, "R7", {name, " end-of-frame bit errors"}, bad_eof, 0);
        chk(hs_cnt == n_exp, hs_req, {name, " bytes accepted"}, hs_cnt, n_exp);
        chk(r9_bad == 0, "R9", {name, " changes without enable"}, r9_bad, 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            bit_en = 1'b1;
            in_valid = 1'b0;
        end
        @(negedge clk);
        chk(tx_bit === 1'b1 && tx_busy === 1'b0 && in_ready === 1'b0, "R1",
            {name, " idle after frame"}, {tx_bit, tx_busy, in_ready}, 3'b100);
        en_prev = 1'b0;
        bit_en  = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; bit_en = 1'b0; in_valid = 1'b0; in_data = '0; in_last = 1'b0;
        en_prev = 1'b0; rand_en = 1'b0; en_mod = 1; prev_tx = 1'b1;
        repeat (3) @(negedge clk);
        chk(tx_bit === 1'b1 && tx_busy === 1'b0 && in_ready === 1'b0, "R1",
            "reset state", {tx_bit, tx_busy, in_ready}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);

        // one byte with last marker
        src_q = '{8'hA5};
        run_frame(1, 1, 1'b1, 0, "R5", "single byte");

        // extreme data patterns, bit order check
        src_q = '{8'h00, 8'hFF, 8'h81};
        run_frame(3, 3, 1'b1, 2, "R4", "pattern bytes");

        // no byte at the first boundary: empty frame
        src_q.delete();
        run_frame(0, 0, 1'b0, -1, "R8", "empty frame underrun");

        // source stalls after two bytes without last
        src_q = '{8'h3C, 8'hC3, 8'h55};
        run_frame(2, 2, 1'b0, -1, "R8", "mid-frame underrun");

        // bytes keep coming after the last-marked one
        src_q = '{8'h12, 8'h34, 8'h56, 8'h78};
        run_frame(2, 4, 1'b1, 1, "R6", "extra bytes after last");

        // random frames with sparse bit enables
        rand_en = 1'b1;
        for (int f = 0; f < 20 && !wd; f++) begin
            int n;
            n = 1 + ($urandom % 6);
            en_mod = 1 + ($urandom % 4);
            src_q.delete();
            for (int b = 0; b < n; b++) src_q.push_back(8'($urandom));
            run_frame(n, n, 1'b1, n - 1, "R5", "random frame");
        end

        if (wd) chk(1'b0, "R7", "watchdog expired", cycles, 150000);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule